// File: doc/BRIEF.md
# Lazy Condition-Flag Evaluator

This block turns a recorded operation into condition flags and folds them into a status word. Its inputs are the operation class, an operand size of 1, 2 or 4 bytes, the source, destination and result values, and the multiply high word. It does not produce any arithmetic result. It only rebuilds the negative, zero, overflow and carry flags, plus a separate "R" flag for the MCP add variant. It works them out from the sign bits of the operands and the result, the zero test of the result, and, for multiplies, the 64-bit product. A core can therefore record only the operands of its last flag-setting operation and materialise the flags later, when something reads them.

The new flags are merged into the current status word through an update mask. The extended-arithmetic X bit is always part of that mask, so every evaluation clears X. When the incoming X state is set, a new Z of 1 cannot overwrite the old Z. This makes Z sticky: a chain of multi-word operations can clear it but never set it. Bit-test works differently. It rewrites N and Z from one selected bit, and it clears V and C as well when the core is a legacy one.

The evaluator is combinational. A parameter chooses whether the merged status word goes through one output register (the default) or straight to the port.

Top module: `flag_eval_top`

## Requirements
- R1: Operation classes are coded on `op_i` as add=0, sub=1, compare=2, move/logic/shift=3, unsigned multiply=4, signed multiply=5, MCP=6, bit-test=7. For add at size `size_i` (1, 2 or 4 bytes, sign bit 7, 15 or 31), a result with its sign bit set produces N. It also produces V when both operand sign bits are 0, and C when both are 1.
- R2: For add, a result with its sign bit clear produces Z when the result's low `size_i` bytes are all zero. It produces V when both operand sign bits are 1, and C when either operand sign bit is 1. Result bits above the size are ignored.
- R3: Sub and compare apply the add rules of R1 and R2 to the bitwise inverse of the source and then invert C.
- R4: MCP always applies the 4-byte add rules whatever `size_i` holds. The carry outcome goes to the R bit at position `R_POS` (default 8) instead of C.
- R5: Move/logic/shift produces N from the result sign bit at the selected size and Z when the result's low `size_i` bytes are zero. It never produces V or C.
- R6: Unsigned multiply forms {hi_i, res_i}. It produces Z when that value is zero, N when bit 63 is 1, and V whenever hi_i is nonzero.
- R7: Signed multiply produces Z and N from the signed 64-bit value {hi_i, res_i}. It produces V when hi_i differs from 32 copies of res_i[31].
- R8: Status bits sit at C=0, V=1, Z=2, N=3, X=4. For every class except bit-test, the effective mask is `mask_i` with bit 4 added. Bits inside that mask take the new flag value (0 when no flag is produced). Bits outside it keep their `stat_i` value.
- R9: When `xmode_i` is 1 and the new Z is 1, Z is removed from the effective mask and the old Z is kept. When the new Z is 0, Z is written as in R8.
- R10: Bit-test uses `src_i[4:0]` as the bit index into `dst_i`. It ignores `mask_i` and clears X, N and Z. It also clears V and C when `legacy_i` is 1. It then sets N to the selected bit, and sets Z when the selected bit and every bit below it are 0. All other status bits pass through unchanged.
- R11: With `REG_OUT`=1, `stat_o` shows the merged word one clock after the inputs are applied. It reads zero while `rst_n` is low.
- R12: A `size_i` value other than 1, 2 or 4 produces no flags for add, sub, compare and move. Every bit in the effective mask is then cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation class code |
| size_i | input | 3 | Operand size in bytes (1, 2, 4) |
| src_i | input | 32 | Source operand; bit index for bit-test |
| dst_i | input | 32 | Destination operand; tested value for bit-test |
| res_i | input | 32 | Result, or low product word |
| hi_i | input | 32 | High product word |
| mask_i | input | 32 | Flag update mask |
| xmode_i | input | 1 | Extended-arithmetic state |
| legacy_i | input | 1 | Legacy core: bit-test also clears V and C |
| stat_i | input | 32 | Current status word |
| stat_o | output | 32 | Updated status word |

## Verification
The embedded assertions watch the properties that must hold on every cycle. X never survives an evaluation. Bits outside the effective mask are preserved. A Z that is clear cannot be set while the X state is on. Unsigned overflow always follows a nonzero high word. The output register reproduces the previous cycle's merged word. What the flag values themselves should be for each class, size and operand-sign combination can only be shown by the bench's vectors, which compare against hand-derived words. The same holds for the bit-test masking below the index, for the legacy clearing, and for the behaviour with an unknown size.

// File: rtl/flag_eval_pkg.sv
package flag_eval_pkg;

    typedef enum logic [2:0] {
        OPC_ADD  = 3'd0,
        OPC_SUB  = 3'd1,
        OPC_CMP  = 3'd2,
        OPC_MOVE = 3'd3,
        OPC_MULU = 3'd4,
        OPC_MULS = 3'd5,
        OPC_MCP  = 3'd6,
        OPC_BTST = 3'd7
    } opclass_e;

    localparam int unsigned BIT_C = 0;
    localparam int unsigned BIT_V = 1;
    localparam int unsigned BIT_Z = 2;
    localparam int unsigned BIT_N = 3;
    localparam int unsigned BIT_X = 4;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } nzvc_t;

endpackage

// File: rtl/fe_arith.sv
module fe_arith
    import flag_eval_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [2:0]        size_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] res_i,
    input  logic              inv_src_i,
    input  logic              move_i,
    output nzvc_t             flags_o
);
    localparam int unsigned MSB_W = DATA_W - 1;

    logic [DATA_W-1:0] szmask;
    logic [DATA_W-1:0] src_eff;
    logic              known;
    logic              s_m, d_m, r_m, zero;
    int unsigned       top;

    always_comb begin
        known  = 1'b1;
        top    = MSB_W;
        szmask = '1;
        unique case (size_i)
            3'd1:    begin top = 7;  szmask = DATA_W'({8{1'b1}});  end
            3'd2:    begin top = 15; szmask = DATA_W'({16{1'b1}}); end
            3'd4:    begin top = MSB_W; szmask = '1;               end
            default: begin known = 1'b0;                            end
        endcase
        src_eff = inv_src_i ? ~src_i : src_i;
        s_m  = src_eff[top];
        d_m  = dst_i[top];
        r_m  = res_i[top];
        zero = ((res_i & szmask) == '0);

        flags_o = '0;
        if (known) begin
            if (move_i) begin
                flags_o.n = r_m;
                flags_o.z = zero;
            end else begin
                if (r_m) begin
                    flags_o.n = 1'b1;
                    flags_o.v = !s_m && !d_m;
                    flags_o.c = s_m && d_m;
                end else begin
                    flags_o.z = zero;
                    flags_o.v = s_m && d_m;
                    flags_o.c = s_m || d_m;
                end
                flags_o.c = flags_o.c ^ inv_src_i;
            end
        end
    end
endmodule

// File: rtl/fe_mul.sv
module fe_mul
    import flag_eval_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              signed_i,
    input  logic [DATA_W-1:0] lo_i,
    input  logic [DATA_W-1:0] hi_i,
    output nzvc_t             flags_o
);
    localparam int unsigned WIDE_W = 2 * DATA_W;

    logic [WIDE_W-1:0] wide;
    logic [DATA_W-1:0] ext;

    always_comb begin
        wide      = {hi_i, lo_i};
        ext       = {DATA_W{lo_i[DATA_W-1]}};
        flags_o   = '0;
        flags_o.z = (wide == '0);
        flags_o.n = wide[WIDE_W-1];
        flags_o.v = signed_i ? (hi_i != ext) : (hi_i != '0);
    end
endmodule

// File: rtl/fe_btst.sv
module fe_btst
    import flag_eval_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned STAT_W = 32
) (
    input  logic [DATA_W-1:0]         val_i,
    input  logic [$clog2(DATA_W)-1:0] idx_i,
    input  logic                      legacy_i,
    input  logic [STAT_W-1:0]         stat_i,
    output logic [STAT_W-1:0]         stat_o
);
    localparam int unsigned IDX_W = $clog2(DATA_W);

    logic [DATA_W-1:0] low_mask;
    logic [STAT_W-1:0] clr;
    logic              bit_set, below_zero;

    always_comb begin
        low_mask   = {DATA_W{1'b1}} >> (IDX_W'(DATA_W - 1) - idx_i);
        bit_set    = val_i[idx_i];
        below_zero = ((val_i & low_mask) == '0);
        clr        = '0;
        clr[BIT_X] = 1'b1;
        clr[BIT_N] = 1'b1;
        clr[BIT_Z] = 1'b1;
        if (legacy_i) begin
            clr[BIT_V] = 1'b1;
            clr[BIT_C] = 1'b1;
        end
        stat_o        = stat_i & ~clr;
        stat_o[BIT_N] = bit_set;
        stat_o[BIT_Z] = below_zero;
    end
endmodule

// File: rtl/fe_merge.sv
module fe_merge
    import flag_eval_pkg::*;
#(
    parameter int unsigned STAT_W = 32
) (
    input  logic [STAT_W-1:0] flags_i,
    input  logic [STAT_W-1:0] mask_i,
    input  logic              xmode_i,
    input  logic [STAT_W-1:0] stat_i,
    output logic [STAT_W-1:0] stat_o
);
    logic [STAT_W-1:0] eff;

    always_comb begin
        eff        = mask_i;
        eff[BIT_X] = 1'b1;
        if (xmode_i && flags_i[BIT_Z]) begin
            eff[BIT_Z] = 1'b0;
        end
        stat_o = (stat_i & ~eff) | (flags_i & eff);
    end
endmodule

// File: rtl/flag_eval_top.sv
module flag_eval_top
    import flag_eval_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned STAT_W  = 32,
    parameter int unsigned R_POS   = 8,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_i,
    input  logic [2:0]        size_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] res_i,
    input  logic [DATA_W-1:0] hi_i,
    input  logic [STAT_W-1:0] mask_i,
    input  logic              xmode_i,
    input  logic              legacy_i,
    input  logic [STAT_W-1:0] stat_i,
    output logic [STAT_W-1:0] stat_o
);
    localparam int unsigned IDX_W = $clog2(DATA_W);

    typedef struct packed {
        logic [STAT_W-1:0] stat;
    } state_t;

    opclass_e          opc;
    logic [2:0]        ar_size;
    nzvc_t             ar_f, mul_f, pick;
    logic [STAT_W-1:0] new_flags, merged, btst_stat;
    logic              is_mul;
    state_t            state_d;

    assign opc     = opclass_e'(op_i);
    assign ar_size = (opc == OPC_MCP) ? 3'd4 : size_i;
    assign is_mul  = (opc == OPC_MULU) || (opc == OPC_MULS);

    fe_arith #(.DATA_W(DATA_W)) u_arith (
        .size_i    (ar_size),
        .src_i     (src_i),
        .dst_i     (dst_i),
        .res_i     (res_i),
        .inv_src_i ((opc == OPC_SUB) || (opc == OPC_CMP)),
        .move_i    (opc == OPC_MOVE),
        .flags_o   (ar_f)
    );

    fe_mul #(.DATA_W(DATA_W)) u_mul (
        .signed_i (opc == OPC_MULS),
        .lo_i     (res_i),
        .hi_i     (hi_i),
        .flags_o  (mul_f)
    );

    fe_btst #(.DATA_W(DATA_W), .STAT_W(STAT_W)) u_btst (
        .val_i    (dst_i),
        .idx_i    (src_i[IDX_W-1:0]),
        .legacy_i (legacy_i),
        .stat_i   (stat_i),
        .stat_o   (btst_stat)
    );

    fe_merge #(.STAT_W(STAT_W)) u_merge (
        .flags_i (new_flags),
        .mask_i  (mask_i),
        .xmode_i (xmode_i),
        .stat_i  (stat_i),
        .stat_o  (merged)
    );

    always_comb begin
        pick             = is_mul ? mul_f : ar_f;
        new_flags        = '0;
        new_flags[BIT_N] = pick.n;
        new_flags[BIT_Z] = pick.z;
        new_flags[BIT_V] = pick.v;
        if (opc == OPC_MCP) begin
            new_flags[R_POS] = pick.c;
        end else begin
            new_flags[BIT_C] = pick.c;
        end
        state_d.stat = (opc == OPC_BTST) ? btst_stat : merged;
    end

    generate
        if (REG_OUT) begin : g_reg
            state_t state_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) state_q <= '0;
                else        state_q <= state_d;
            end
            assign stat_o = state_q.stat;

            // R11
            reg_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (stat_o == $past(state_d.stat)));
        end else begin : g_comb
            assign stat_o = state_d.stat;
        end
    endgenerate

    // R8
    x_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opc != OPC_BTST) |-> !state_d.stat[BIT_X]);

    // R8
    outside_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opc != OPC_BTST) |->
        (((state_d.stat ^ stat_i) & ~(mask_i | (STAT_W'(1) << BIT_X))) == '0));

    // R9
    sticky_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opc != OPC_BTST && xmode_i && !stat_i[BIT_Z]) |-> !state_d.stat[BIT_Z]);

    // R6
    mulu_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == OPC_MULU && hi_i != '0 && mask_i[BIT_V]) |-> state_d.stat[BIT_V]);

    // R10
    btst_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == OPC_BTST) |-> !state_d.stat[BIT_X]);
endmodule

// File: tb/flag_eval_top_test.sv
module flag_eval_top_test;

    typedef struct packed {
        logic [2:0]  op;
        logic [2:0]  size;
        logic [31:0] src;
        logic [31:0] dst;
        logic [31:0] res;
        logic [31:0] hi;
        logic [31:0] mask;
        logic        x;
        logic        leg;
        logic [31:0] stat;
        logic [31:0] expv;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 29;
    localparam logic [31:0] M = 32'h0000_010F;

    localparam vec_t TBL [NV] = '{
        // R1 add, negative result, both operands positive
        '{3'd0, 3'd4, 32'h7000_0000, 32'h7000_0000, 32'hE000_0000, 32'h0, M, 1'b0, 1'b0, 32'h0, 32'h0000_000A, 4'd1},
        // R2 add, positive result, both operands negative, bits outside mask kept
        '{3'd0, 3'd4, 32'h8000_0000, 32'h8000_0001, 32'h0000_0001, 32'h0, M, 1'b0, 1'b0, 32'hF0, 32'h0000_00E3, 4'd2},
        // R2 zero result
        '{3'd0, 3'd4, 32'h0, 32'h0, 32'h0, 32'h0, M, 1'b0, 1'b0, 32'h0, 32'h0000_0004, 4'd2},
        // R2 byte size ignores upper result bits
        '{3'd0, 3'd1, 32'h80, 32'h80, 32'h100, 32'h0, M, 1'b0, 1'b0, 32'h0, 32'h0000_0007, 4'd2},
        // R1 word size
        '{3'd0, 3'd2, 32'h8000, 32'h8000, 32'h0001_8000, 32'h0, M, 1'b0, 1'b0, 32'h0, 32'h0000_0009, 4'd1},
        // R3 sub equal operands
        '{3'd1, 3'd4, 32'h1, 32'h1, 32'h0, 32'h0, M, 1'b0, 1'b0, 32'h0, 32'h0000_0004, 4'd3},
        // R3 compare with borrow
        '{3'd2, 3'd4, 32'h1, 32'h0, 32'hFFFF_FFFF, 32'h0, M, 1'b0, 1'b0, 32'h0, 32'h0000_0009, 4'd3},
        // R3 compare byte overflow
        '{3'd2, 3'd1, 32'h1, 32'h80, 32'h7F, 32'h0, M, 1'b0, 1'b0, 32'h0, 32'h0000_0002, 4'd3},
        // R4 MCP, size input ignored, carry into R
        '{3'd6, 3'd1, 32'h8000_0000, 32'h8000_0000, 32'h0, 32'h0, M, 1'b0, 1'b0, 32'h1, 32'h0000_0106, 4'd4},
        // R5 move long negative
        '{3'd3, 3'd4, 32'h0, 32'h0, 32'h8000_0000, 32'h0, M, 1'b0, 1'b0, 32'h3, 32'h0000_0008, 4'd5},
        // R5 move word zero
        '{3'd3, 3'd2, 32'h0, 32'h0, 32'h0001_0000, 32'h0, M, 1'b0, 1'b0, 32'h0, 32'h0000_0004, 4'd5},
        // R5 move byte negative
        '{3'd3, 3'd1, 32'h0, 32'h0, 32'h80, 32'h0, M, 1'b0, 1'b0, 32'h0, 32'h0000_0008, 4'd5},
        // R6 unsigned multiply zero
        '{3'd4, 3'd4, 32'h0, 32'h0, 32'h0, 32'h0, M, 1'b0, 1'b0, 32'h0, 32'h0000_0004, 4'd6},
        // R6 nonzero high word
        '{3'd4, 3'd4, 32'h0, 32'h0, 32'h0, 32'h1, M, 1'b0, 1'b0, 32'h0, 32'h0000_0002, 4'd6},
        // R6 bit 63 set
        '{3'd4, 3'd4, 32'h0, 32'h0, 32'h0, 32'h8000_0000, M, 1'b0, 1'b0, 32'h0, 32'h0000_000A, 4'd6},
        // R7 signed multiply minus one
        '{3'd5, 3'd4, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, M, 1'b0, 1'b0, 32'h0, 32'h0000_0008, 4'd7},
        // R7 positive but low word looks negative
        '{3'd5, 3'd4, 32'h0, 32'h0, 32'h8000_0000, 32'h0, M, 1'b0, 1'b0, 32'h0, 32'h0000_0002, 4'd7},
        // R7 zero
        '{3'd5, 3'd4, 32'h0, 32'h0, 32'h0, 32'h0, M, 1'b0, 1'b0, 32'h0, 32'h0000_0004, 4'd7},
        // R8 narrow mask keeps the other flags
        '{3'd0, 3'd4, 32'h7000_0000, 32'h7000_0000, 32'hE000_0000, 32'h0, 32'h8, 1'b0, 1'b0, 32'h107, 32'h0000_010F, 4'd8},
        // R9 X on, old Z clear, new Z 1: Z stays clear, X cleared
        '{3'd0, 3'd4, 32'h0, 32'h0, 32'h0, 32'h0, M, 1'b1, 1'b0, 32'h10, 32'h0000_0000, 4'd9},
        // R9 X on, new Z 0 clears old Z
        '{3'd0, 3'd4, 32'h0, 32'h0, 32'h1, 32'h0, M, 1'b1, 1'b0, 32'h14, 32'h0000_0000, 4'd9},
        // R9 X on, old Z set, new Z 1 keeps it
        '{3'd0, 3'd4, 32'h0, 32'h0, 32'h0, 32'h0, M, 1'b1, 1'b0, 32'h14, 32'h0000_0004, 4'd9},
        // R10 bit-test, bit set
        '{3'd7, 3'd4, 32'h4, 32'h10, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h1F, 32'h0000_000B, 4'd10},
        // R10 legacy clears V and C, upper bits pass
        '{3'd7, 3'd4, 32'h3, 32'h100, 32'h0, 32'h0, 32'h0, 1'b0, 1'b1, 32'hFF1F, 32'h0000_FF04, 4'd10},
        // R10 index 31 from low five bits
        '{3'd7, 3'd4, 32'hFFFF_FFFF, 32'h8000_0000, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0000_0008, 4'd10},
        // R10 bits above the index ignored
        '{3'd7, 3'd4, 32'h7, 32'hFFFF_FF00, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0000_0004, 4'd10},
        // R12 unknown size produces no flags
        '{3'd0, 3'd3, 32'h0, 32'h0, 32'h0, 32'h0, M, 1'b0, 1'b0, 32'hF, 32'h0000_0000, 4'd12},
        // R7 high word not a sign extension, negative value
        '{3'd5, 3'd4, 32'h0, 32'h0, 32'h1, 32'hFFFF_FFFF, M, 1'b0, 1'b0, 32'h0, 32'h0000_000A, 4'd7},
        // R4 MCP negative result from negative operands
        '{3'd6, 3'd4, 32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 32'h0, M, 1'b0, 1'b0, 32'h0, 32'h0000_0108, 4'd4}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_i = '0;
    logic [2:0]  size_i = 3'd4;
    logic [31:0] src_i = '0, dst_i = '0, res_i = '0, hi_i = '0;
    logic [31:0] mask_i = '0, stat_i = '0;
    logic        xmode_i = 1'b0, legacy_i = 1'b0;
    logic [31:0] stat_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    flag_eval_top uut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .size_i(size_i),
        .src_i(src_i), .dst_i(dst_i), .res_i(res_i), .hi_i(hi_i),
        .mask_i(mask_i), .xmode_i(xmode_i), .legacy_i(legacy_i),
        .stat_i(stat_i), .stat_o(stat_o)
    );

    task automatic drive(input vec_t v);
        op_i = v.op; size_i = v.size; src_i = v.src; dst_i = v.dst;
        res_i = v.res; hi_i = v.hi; mask_i = v.mask; xmode_i = v.x;
        legacy_i = v.leg; stat_i = v.stat;
    endtask

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] expv);
        n_chk++;
        if (got !== expv) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, expv);
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        drive(TBL[0]);
        repeat (3) @(negedge clk);
        // R11 reset holds output at zero
        check("R11 reset", stat_o, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(TBL[i]);
            @(negedge clk);
            check($sformatf("R%0d vec %0d", TBL[i].req, i), stat_o, TBL[i].expv);
        end

        // R11 one-cycle latency: new inputs do not show before the edge
        @(negedge clk);
        drive(TBL[0]);
        @(negedge clk);
        drive(TBL[2]);
        #1;
        check("R11 before edge", stat_o, 32'h0000_000A);
        @(negedge clk);
        check("R11 after edge", stat_o, 32'h0000_0004);

        // R11 reset in mid-run clears the output
        rst_n = 1'b0;
        #1;
        check("R11 async reset", stat_o, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 after release", stat_o, 32'h0000_0004);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule